// File: doc/BRIEF.md
# Pixel Clock Synthesizer Parameter Search

This block picks the multiplier and divider codes for a frequency synthesizer whose output is the reference frequency times a multiplier, divided by a divider. The reference is given in Hz and the requested pixel rate in kHz. A search engine walks every (multiplier, divider) pair, one candidate at a time. For each pair it computes the resulting rate in kHz with a shared restoring divider and keeps the pair whose rate lies closest to the request.

A caller pulses the start strobe with the reference frequency and target rate on the inputs. The block captures both and scans the whole code space. When the scan ends it presents the chosen codes and a packed configuration word, and it flags completion with a one-cycle done pulse. The time from start to done depends only on the parameters, never on the operands.

Top module: `pixclk_synth_search`

## Requirements
- R1: Both codes span 1 to MAX, where MAX = 2^CODE_W - 1 (63 by default). While a search runs, the candidate codes never leave that range.
- R2: The multiplier is the outer loop and counts down from MAX to 1. For each multiplier value, the divider counts down from MAX to 1.
- R3: A candidate's rate is floor(floor(mult × fref / 1000) / div), where each division truncates.
- R4: The best error starts at the largest representable value, so the first candidate is always taken. A later candidate replaces the best when its absolute error is less than or equal to the best error, so the later of two equal candidates wins.
- R5: The configuration word holds (mult-1) in the bits from bit 8 upward ([13:8] when CODE_W=6) and (div-1) in the bits from bit 0 upward ([5:0] when CODE_W=6). Every other bit of the 16-bit word is zero.
- R6: The chosen codes are clamped into 1..MAX before they are packed and presented.
- R7: The block captures fref and the target at the start strobe. A start strobe that arrives while a search is busy is ignored, and so is any change of the inputs during a search.
- R8: done_o is high for exactly one cycle per search. The code outputs and the word change only in the cycle that done_o rises and hold between searches. busy_o is high from the cycle after an accepted start until done_o rises.
- R9: The number of cycles from an accepted start to done_o is the same for every fref and every target.
- R10: After reset, busy_o and done_o are low and all code and word outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| fref_i | input | REF_W | Reference frequency in Hz |
| rate_i | input | RATE_W | Requested pixel rate in kHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| best_v_o | output | CODE_W | Chosen multiplier code (1..MAX) |
| best_r_o | output | CODE_W | Chosen divider code (1..MAX) |
| word_o | output | 16 | Packed configuration word |

## Verification
The bench builds the block with CODE_W=3, REF_W=16 and RATE_W=16, which shrinks the code space to 7×7 candidates. At that size a full search costs about a thousand cycles, so dozens of reference/target pairs can be scanned completely and compared with an arithmetic model in the bench. The chosen targets include exact multi-way ties, a zero target, and targets above the largest reachable rate. These make the descending scan order and the tie rule visible at the ports. The bench also compares the start-to-done cycle count across every search, and it fires a second start with different operands in the middle of a search.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;

    localparam int KHZ_DIVISOR  = 1000;
    localparam int WORD_W       = 16;
    localparam int MULT_LSB     = 8;
    localparam int DIV_LSB      = 0;

    typedef logic [63:0] wide_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCALE_GO,
        ST_SCALE_WAIT,
        ST_DIV_GO,
        ST_DIV_WAIT,
        ST_COMMIT
    } scan_state_e;

    function automatic wide_t abs_diff(input wide_t a, input wide_t b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/pixclk_div.sv
module pixclk_div #(
    parameter int N_W = 22,
    parameter int D_W = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [N_W-1:0] num_i,
    input  logic [D_W-1:0] den_i,
    output logic           done_o,
    output logic [N_W-1:0] quo_o
);
    localparam int CNT_W = $clog2(N_W + 1);

    logic [D_W-1:0]   rem_q;
    logic [D_W-1:0]   den_q;
    logic [N_W-1:0]   quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             done_q;

    logic [D_W:0] shifted;
    logic [D_W:0] trial;

    always_comb begin
        shifted = {rem_q, quo_q[N_W-1]};
        trial   = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            den_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                rem_q <= '0;
                den_q <= den_i;
                quo_q <= num_i;
                cnt_q <= CNT_W'(N_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (!trial[D_W]) begin
                    rem_q <= trial[D_W-1:0];
                    quo_q <= {quo_q[N_W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[D_W-1:0];
                    quo_q <= {quo_q[N_W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign quo_o  = quo_q;

    // R3
    rem_below_den_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (rem_q < den_q));

endmodule

// File: rtl/pixclk_scan_ctrl.sv
module pixclk_scan_ctrl
    import pixclk_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int REF_W  = 32,
    parameter int RATE_W = 32,
    parameter int N_W    = CODE_W + REF_W,
    parameter int D_W    = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [REF_W-1:0]  fref_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              div_start_o,
    output logic [N_W-1:0]    div_num_o,
    output logic [D_W-1:0]    div_den_o,
    input  logic              div_done_i,
    input  logic [N_W-1:0]    div_quo_i,
    output logic              init_o,
    output logic              eval_o,
    output logic [CODE_W-1:0] cand_v_o,
    output logic [CODE_W-1:0] cand_r_o,
    output logic [RATE_W-1:0] tgt_o,
    output logic              commit_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

    scan_state_e       state_q;
    logic [REF_W-1:0]  fref_q;
    logic [RATE_W-1:0] tgt_q;
    logic [CODE_W-1:0] v_q;
    logic [CODE_W-1:0] r_q;
    logic [N_W-1:0]    scaled_q;
    logic              done_q;

    always_comb begin
        div_start_o = (state_q == ST_SCALE_GO) || (state_q == ST_DIV_GO);
        if (state_q == ST_SCALE_GO) begin
            div_num_o = N_W'(v_q) * N_W'(fref_q);
            div_den_o = D_W'(KHZ_DIVISOR);
        end else begin
            div_num_o = scaled_q;
            div_den_o = D_W'(r_q);
        end
        init_o   = (state_q == ST_IDLE) && start_i;
        eval_o   = (state_q == ST_DIV_WAIT) && div_done_i;
        commit_o = (state_q == ST_COMMIT);
        busy_o   = (state_q != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            fref_q   <= '0;
            tgt_q    <= '0;
            v_q      <= '0;
            r_q      <= '0;
            scaled_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state_q == ST_COMMIT);
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        fref_q  <= fref_i;
                        tgt_q   <= rate_i;
                        v_q     <= CODE_MAX;
                        r_q     <= CODE_MAX;
                        state_q <= ST_SCALE_GO;
                    end
                end
                ST_SCALE_GO: state_q <= ST_SCALE_WAIT;
                ST_SCALE_WAIT: begin
                    if (div_done_i) begin
                        scaled_q <= div_quo_i;
                        state_q  <= ST_DIV_GO;
                    end
                end
                ST_DIV_GO: state_q <= ST_DIV_WAIT;
                ST_DIV_WAIT: begin
                    if (div_done_i) begin
                        if (r_q == CODE_ONE) begin
                            if (v_q == CODE_ONE) begin
                                state_q <= ST_COMMIT;
                            end else begin
                                v_q     <= v_q - 1'b1;
                                r_q     <= CODE_MAX;
                                state_q <= ST_SCALE_GO;
                            end
                        end else begin
                            r_q     <= r_q - 1'b1;
                            state_q <= ST_DIV_GO;
                        end
                    end
                end
                ST_COMMIT: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign cand_v_o = v_q;
    assign cand_r_o = r_q;
    assign tgt_o    = tgt_q;
    assign done_o   = done_q;

    // R1
    cand_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> ((v_q != '0) && (r_q != '0)));

    // R7
    tgt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> ($stable(tgt_q) && $stable(fref_q)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: rtl/pixclk_best_track.sv
module pixclk_best_track
    import pixclk_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int RATE_W = 32,
    parameter int N_W    = 38
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_i,
    input  logic              eval_i,
    input  logic [N_W-1:0]    freq_i,
    input  logic [RATE_W-1:0] tgt_i,
    input  logic [CODE_W-1:0] cand_v_i,
    input  logic [CODE_W-1:0] cand_r_i,
    output logic [CODE_W-1:0] best_v_o,
    output logic [CODE_W-1:0] best_r_o
);
    localparam int EW = (N_W > RATE_W) ? N_W : RATE_W;

    logic [EW-1:0]     err_w;
    logic [EW-1:0]     best_err_q;
    logic [CODE_W-1:0] best_v_q;
    logic [CODE_W-1:0] best_r_q;
    logic              take_w;

    always_comb begin
        err_w  = EW'(abs_diff(64'(freq_i), 64'(tgt_i)));
        take_w = eval_i && (err_w <= best_err_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            best_err_q <= '1;
            best_v_q   <= '0;
            best_r_q   <= '0;
        end else if (init_i) begin
            best_err_q <= '1;
        end else if (take_w) begin
            best_err_q <= err_w;
            best_v_q   <= cand_v_i;
            best_r_q   <= cand_r_i;
        end
    end

    assign best_v_o = best_v_q;
    assign best_r_o = best_r_q;

    // R4
    err_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        !init_i |=> (best_err_q <= $past(best_err_q)));

    // R4
    tie_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (eval_i && !init_i && (err_w == best_err_q)) |=>
            (best_v_q == $past(cand_v_i) && best_r_q == $past(cand_r_i)));

endmodule

// File: rtl/pixclk_synth_search.sv
module pixclk_synth_search
    import pixclk_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int REF_W  = 32,
    parameter int RATE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [REF_W-1:0]  fref_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [CODE_W-1:0] best_v_o,
    output logic [CODE_W-1:0] best_r_o,
    output logic [15:0]       word_o
);
    // CODE_W must stay at or below 8 so that both fields fit the word.
    localparam int N_W = CODE_W + REF_W;
    localparam int D_W = (CODE_W > 10) ? CODE_W : 10;
    localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

    logic              div_start;
    logic [N_W-1:0]    div_num;
    logic [D_W-1:0]    div_den;
    logic              div_done;
    logic [N_W-1:0]    div_quo;
    logic              init_w;
    logic              eval_w;
    logic              commit_w;
    logic [CODE_W-1:0] cand_v;
    logic [CODE_W-1:0] cand_r;
    logic [RATE_W-1:0] tgt;
    logic [CODE_W-1:0] trk_v;
    logic [CODE_W-1:0] trk_r;

    logic [CODE_W-1:0] clamp_v;
    logic [CODE_W-1:0] clamp_r;
    logic [CODE_W-1:0] out_v_q;
    logic [CODE_W-1:0] out_r_q;
    logic [WORD_W-1:0] word_q;

    pixclk_scan_ctrl #(
        .CODE_W(CODE_W), .REF_W(REF_W), .RATE_W(RATE_W), .N_W(N_W), .D_W(D_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .fref_i(fref_i), .rate_i(rate_i),
        .div_start_o(div_start), .div_num_o(div_num), .div_den_o(div_den),
        .div_done_i(div_done), .div_quo_i(div_quo),
        .init_o(init_w), .eval_o(eval_w), .cand_v_o(cand_v), .cand_r_o(cand_r),
        .tgt_o(tgt), .commit_o(commit_w), .busy_o(busy_o), .done_o(done_o)
    );

    pixclk_div #(.N_W(N_W), .D_W(D_W)) u_div (
        .clk(clk), .rst(rst), .start_i(div_start), .num_i(div_num),
        .den_i(div_den), .done_o(div_done), .quo_o(div_quo)
    );

    pixclk_best_track #(.CODE_W(CODE_W), .RATE_W(RATE_W), .N_W(N_W)) u_track (
        .clk(clk), .rst(rst), .init_i(init_w), .eval_i(eval_w),
        .freq_i(div_quo), .tgt_i(tgt), .cand_v_i(cand_v), .cand_r_i(cand_r),
        .best_v_o(trk_v), .best_r_o(trk_r)
    );

    always_comb begin
        clamp_v = (trk_v == '0) ? CODE_ONE : trk_v;
        clamp_r = (trk_r == '0) ? CODE_ONE : trk_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v_q <= '0;
            out_r_q <= '0;
            word_q  <= '0;
        end else if (commit_w) begin
            out_v_q <= clamp_v;
            out_r_q <= clamp_r;
            word_q  <= (WORD_W'(clamp_v - CODE_ONE) << MULT_LSB)
                     | (WORD_W'(clamp_r - CODE_ONE) << DIV_LSB);
        end
    end

    assign best_v_o = out_v_q;
    assign best_r_o = out_r_q;
    assign word_o   = word_q;

    // R6
    clamp_range_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((out_v_q != '0) && (out_r_q != '0)));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit_w |=> $stable(word_q) && $stable(out_v_q) && $stable(out_r_q));

    // R5
    word_field_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (word_q[MULT_LSB +: CODE_W] == out_v_q - CODE_ONE));

endmodule

// File: tb/pixclk_synth_search_tb.sv
`timescale 1ns/1ps
module pixclk_synth_search_tb;
    localparam int CODE_W = 3;
    localparam int REF_W  = 16;
    localparam int RATE_W = 16;
    localparam int MAXC   = (1 << CODE_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [REF_W-1:0]  fref_i = '0;
    logic [RATE_W-1:0] rate_i = '0;
    logic              busy_o, done_o;
    logic [CODE_W-1:0] best_v_o, best_r_o;
    logic [15:0]       word_o;

    int errors = 0;
    int checks = 0;
    int ref_lat = -1;

    always #2 clk = ~clk;

    pixclk_synth_search #(.CODE_W(CODE_W), .REF_W(REF_W), .RATE_W(RATE_W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .fref_i(fref_i), .rate_i(rate_i),
        .busy_o(busy_o), .done_o(done_o), .best_v_o(best_v_o),
        .best_r_o(best_r_o), .word_o(word_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Arithmetic model: descending scan, ties to the later candidate.
    task automatic model(input int fref, input int tgt, output int mv, output int mr);
        longint best;
        best = 64'h7fff_ffff_ffff_ffff;
        mv = 0; mr = 0;
        for (int v = MAXC; v >= 1; v--) begin
            for (int r = MAXC; r >= 1; r--) begin
                longint sc, f, e;
                sc = (longint'(v) * fref) / 1000;
                f  = sc / r;
                e  = (f > tgt) ? f - tgt : tgt - f;
                if (e <= best) begin
                    best = e; mv = v; mr = r;
                end
            end
        end
    endtask

    task automatic pulse_start(input int fref, input int tgt);
        @(negedge clk);
        fref_i = REF_W'(fref);
        rate_i = RATE_W'(tgt);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 1;
        while (!done_o && lat < 20000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_one(input int fref, input int tgt, input bit disturb);
        int mv, mr, lat;
        model(fref, tgt, mv, mr);
        pulse_start(fref, tgt);
        check("R8 busy after start", busy_o, 1);
        if (disturb) begin
            repeat (50) @(negedge clk);
            fref_i = 16'd999; rate_i = 16'd3; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            wait_done(lat);
            lat += 51;
        end else begin
            fref_i = ~fref_i; rate_i = ~rate_i;
            wait_done(lat);
        end
        if (!done_o) check("R8 done never seen", 0, 1);
        if (ref_lat < 0) ref_lat = lat;
        check("R9 latency", lat, ref_lat);
        check(disturb ? "R7 ignored restart v" : "R2 R3 R4 best v", best_v_o, mv);
        check(disturb ? "R7 ignored restart r" : "R2 R3 R4 best r", best_r_o, mr);
        check("R5 R6 word", word_o, ((mv - 1) << 8) | (mr - 1));
        check("R1 codes in range", (best_v_o >= 1 && best_r_o >= 1) ? 1 : 0, 1);
        check("R8 busy low at done", busy_o, 0);
        @(negedge clk);
        check("R8 done single pulse", done_o, 0);
        check("R8 word holds", word_o, ((mv - 1) << 8) | (mr - 1));
    endtask

    initial begin
        #(200000 * 4);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int frefs [5] = '{1000, 30000, 65535, 12345, 7777};
        int tgts [13] = '{0, 1, 2, 5, 30, 31, 45, 100, 210, 333, 458, 500, 65535};
        int mv, mr;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 busy", busy_o, 0);
        check("R10 done", done_o, 0);
        check("R10 v", best_v_o, 0);
        check("R10 r", best_r_o, 0);
        check("R10 word", word_o, 0);

        // R4 exact tie: fref 30000, target 30 -> every v==r hits 30; last is 1,1
        model(30000, 30, mv, mr);
        check("R4 tie model sanity v", mv, 1);
        check("R4 tie model sanity r", mr, 1);
        run_one(30000, 30, 1'b0);
        // R2 zero target with fref 1000: last zero-rate candidate is v=1 r=2
        model(1000, 0, mv, mr);
        check("R2 zero model sanity r", mr, 2);

        foreach (frefs[i]) begin
            foreach (tgts[j]) begin
                run_one(frefs[i], tgts[j], 1'b0);
            end
        end

        // R7 start while busy ignored
        run_one(12345, 45, 1'b1);
        run_one(65535, 100, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule